// File: doc/BRIEF.md
# Dual-Core Deep Low-Power Mode Controller

This block decides whether the device may leave Run for one of five deep low-power modes, and which one. A request is taken only on a single-cycle entry strobe. The block then checks three things: every CPU reports its core-stop state, no secure-boot session is active, and the requested mode code is legal. If any check fails, the strobe has no effect. Once a request is accepted, the block runs a fixed-length entry sequence. It then holds a per-mode set of enables for the regulators, the high-speed clock sources, the core supply, the SRAM2 retention domain and the supply monitors.

A wake-up event moves the block into an exit phase. In this phase the main regulator and the chosen restart clock are enabled. The CPUs are released only after that clock reports ready, and the release is marked by a one-cycle done pulse. A wake-up during the entry sequence cancels the entry. The block keeps the last mode it actually entered in a status field. Software clears that field by writing one to it.

Top module: `lp_mode_ctrl`

## Requirements
- R1: An entry strobe starts entry (cpu_hold_o rises on the next cycle) only when every bit of cpu_stop_i is 1. Otherwise the strobe has no effect.
- R2: While secure_boot_i is 1, no entry strobe is accepted.
- R3: Mode codes are 0 = Stop 0, 1 = Stop 1, 2 = Stop 2, 3 = Standby, 4 = Shutdown. A strobe with a code of 5 to 7 is ignored.
- R4: After an accepted strobe, cpu_hold_o is 1. The deep-mode enables apply ENTRY_CYC cycles after the cycle that follows the strobe.
- R5: Stop 0 enable vector: main regulator, core supply, SRAM2 retention and supply monitor are on. The low-power regulator, PLL, multi-speed oscillator, 16 MHz RC and 32 MHz crystal are off.
- R6: Stop 1 and Stop 2 are the same as Stop 0 except that the low-power regulator is on and the main regulator is off.
- R7: Standby turns off the core supply, the main regulator and all high-speed clocks, and forces the voltage detector to its lowest level (pvd_low_o = 1). The low-power regulator and SRAM2 retention follow retain_i as sampled at the strobe.
- R8: Shutdown turns off every enable, including the supply monitor (sup_mon_o = 0).
- R9: clk_sel_o after a wake-up depends on the mode. From Stop 0/1/2 it is 1 (multi-speed at 48 MHz) when wake_hsi_i was 0 at the strobe, and 2 (16 MHz RC) when it was 1. From Standby and Shutdown it is 0 (multi-speed at 4 MHz).
- R10: After wake_i in a deep mode, the main regulator, the core supply and only the selected restart oscillator are enabled. The CPUs stay held until that oscillator's ready input is 1; the ready input of the other oscillator does not release them. Release then comes with a wake_done_o pulse one cycle long.
- R11: wake_i during the entry sequence returns the block to Run: no done pulse, and no change to the status field.
- R12: On entering a deep mode, last_mode_o takes the mode code and last_valid_o goes to 1. A one on stat_clr_i clears last_valid_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_stop_i | input | NCPU | Per-CPU core-stop status |
| entry_req_i | input | 1 | Single-cycle entry strobe |
| mode_i | input | 3 | Requested deep mode code |
| retain_i | input | 1 | SRAM2 retention in Standby |
| secure_boot_i | input | 1 | Secure-boot session active |
| wake_hsi_i | input | 1 | Restart clock choice for Stop modes |
| wake_i | input | 1 | Wake-up event |
| msi_rdy_i | input | 1 | Multi-speed oscillator ready |
| hsi_rdy_i | input | 1 | 16 MHz RC ready |
| stat_clr_i | input | 1 | Write-one-to-clear for the status field |
| main_reg_en_o | output | 1 | Main regulator enable |
| lp_reg_en_o | output | 1 | Low-power regulator enable |
| core_pwr_o | output | 1 | Core domain supply enable |
| pll_en_o | output | 1 | PLL enable |
| msi_en_o | output | 1 | Multi-speed oscillator enable |
| hsi_en_o | output | 1 | 16 MHz RC enable |
| hse_en_o | output | 1 | 32 MHz crystal oscillator enable |
| sram2_ret_o | output | 1 | SRAM2 retention supply |
| pvd_low_o | output | 1 | Force voltage detector to its lowest level |
| sup_mon_o | output | 1 | Supply monitoring enable |
| clk_sel_o | output | 2 | Restart clock: 0 MSI 4 MHz, 1 MSI 48 MHz, 2 HSI16 |
| cpu_hold_o | output | 1 | CPUs held (not in Run) |
| wake_done_o | output | 1 | One-cycle release pulse |
| last_mode_o | output | 3 | Last deep mode entered |
| last_valid_o | output | 1 | Status field holds a record |

## Verification
Each of the five legal modes is tried with retention and restart-clock settings drawn at random. The enable vector, restart clock and status record show that each mode takes its own decode path and does not share one with a neighbouring code. Strobes are also sent with one CPU awake, with secure boot active, and with the illegal codes 5 to 7. These show that each gating condition blocks entry on its own. On each wake-up, the ready input of the wrong oscillator is raised first, which separates a release gated on the selected clock from one gated on either clock. A wake-up during entry and a status clear exercise the abort path and the clear path.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    MODE_STOP0 = 3'd0,
    MODE_STOP1 = 3'd1,
    MODE_STOP2 = 3'd2,
    MODE_STBY  = 3'd3,
    MODE_SHDN  = 3'd4
  } lpm_mode_e;

  typedef enum logic [1:0] {
    WCLK_MSI4  = 2'd0,
    WCLK_MSI48 = 2'd1,
    WCLK_HSI16 = 2'd2
  } wclk_e;

  typedef enum logic [1:0] {ST_RUN, ST_ENTER, ST_DEEP, ST_WAKE} lpm_state_e;

  typedef struct packed {
    logic main_reg;
    logic lp_reg;
    logic core_pwr;
    logic pll;
    logic msi;
    logic hsi;
    logic hse;
    logic sram2_ret;
    logic pvd_low;
    logic sup_mon;
  } pwr_vec_t;

  function automatic logic mode_legal(logic [2:0] m);
    return m <= 3'd4;
  endfunction
endpackage

// File: rtl/lpm_gate.sv
module lpm_gate #(
  parameter int NCPU = 2
) (
  input  logic [NCPU-1:0] cpu_stop_i,
  input  logic            req_i,
  input  logic [2:0]      mode_i,
  input  logic            secure_i,
  input  logic            idle_i,
  output logic            accept_o
);
  logic [NCPU:0] stop_chain;
  assign stop_chain[0] = 1'b1;

  for (genvar g = 0; g < NCPU; g++) begin : g_stop
    assign stop_chain[g+1] = stop_chain[g] & cpu_stop_i[g];
  end

  assign accept_o = req_i & idle_i & stop_chain[NCPU] & ~secure_i &
                    lpm_pkg::mode_legal(mode_i);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int ENTRY_CYC = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        accept_i,
  input  logic [2:0]  mode_i,
  input  logic        retain_i,
  input  logic        wake_hsi_i,
  input  logic        wake_i,
  input  logic        msi_rdy_i,
  input  logic        hsi_rdy_i,
  output lpm_state_e  state_o,
  output lpm_mode_e   mode_o,
  output logic        retain_o,
  output wclk_e       wclk_o,
  output logic        done_o,
  output logic        record_o
);
  localparam int CNT_W = $clog2(ENTRY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRY_CYC - 1);

  lpm_state_e       state_q;
  lpm_mode_e        mode_q;
  wclk_e            wclk_q;
  logic             ret_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic             clk_rdy;

  assign clk_rdy  = (wclk_q == WCLK_HSI16) ? hsi_rdy_i : msi_rdy_i;
  assign record_o = (state_q == ST_ENTER) && (cnt_q == CNT_LAST) && !wake_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      mode_q  <= MODE_STOP0;
      wclk_q  <= WCLK_MSI4;
      ret_q   <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_RUN: if (accept_i) begin
          state_q <= ST_ENTER;
          cnt_q   <= '0;
          mode_q  <= lpm_mode_e'(mode_i);
          ret_q   <= retain_i;
          if (mode_i <= 3'd2) wclk_q <= wake_hsi_i ? WCLK_HSI16 : WCLK_MSI48;
          else                wclk_q <= WCLK_MSI4;
        end
        ST_ENTER: begin
          if (wake_i)                state_q <= ST_RUN;
          else if (cnt_q == CNT_LAST) state_q <= ST_DEEP;
          else                       cnt_q   <= cnt_q + 1'b1;
        end
        ST_DEEP: if (wake_i) state_q <= ST_WAKE;
        ST_WAKE: if (clk_rdy) begin
          state_q <= ST_RUN;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign state_o  = state_q;
  assign mode_o   = mode_q;
  assign retain_o = ret_q;
  assign wclk_o   = wclk_q;
  assign done_o   = done_q;

  AST_DONE_AFTER_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(clk_rdy) && $past(state_q == ST_WAKE)); // R10
  AST_ABORT_TO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ENTER && wake_i) |=> state_q == ST_RUN && !done_q); // R11
endmodule

// File: rtl/lpm_enables.sv
module lpm_enables
  import lpm_pkg::*;
(
  input  lpm_state_e state_i,
  input  lpm_mode_e  mode_i,
  input  logic       retain_i,
  input  wclk_e      wclk_i,
  output pwr_vec_t   vec_o
);
  always_comb begin
    vec_o = '{main_reg: 1'b1, lp_reg: 1'b0, core_pwr: 1'b1, pll: 1'b1,
              msi: 1'b1, hsi: 1'b1, hse: 1'b1, sram2_ret: 1'b1,
              pvd_low: 1'b0, sup_mon: 1'b1};
    unique case (state_i)
      ST_DEEP: begin
        vec_o.pll = 1'b0;
        vec_o.msi = 1'b0;
        vec_o.hsi = 1'b0;
        vec_o.hse = 1'b0;
        unique case (mode_i)
          MODE_STOP0: ;
          MODE_STOP1, MODE_STOP2: begin
            vec_o.main_reg = 1'b0;
            vec_o.lp_reg   = 1'b1;
          end
          MODE_STBY: begin
            vec_o.main_reg  = 1'b0;
            vec_o.core_pwr  = 1'b0;
            vec_o.lp_reg    = retain_i;
            vec_o.sram2_ret = retain_i;
            vec_o.pvd_low   = 1'b1;
          end
          default: begin
            vec_o.main_reg  = 1'b0;
            vec_o.core_pwr  = 1'b0;
            vec_o.sram2_ret = 1'b0;
            vec_o.sup_mon   = 1'b0;
          end
        endcase
      end
      ST_WAKE: begin
        vec_o.pll = 1'b0;
        vec_o.hse = 1'b0;
        vec_o.msi = (wclk_i != WCLK_HSI16);
        vec_o.hsi = (wclk_i == WCLK_HSI16);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lpm_status.sv
module lpm_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       record_i,
  input  logic [2:0] mode_i,
  input  logic       clr_i,
  output logic [2:0] last_mode_o,
  output logic       last_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_mode_o  <= '0;
      last_valid_o <= 1'b0;
    end else if (record_i) begin
      last_mode_o  <= mode_i;
      last_valid_o <= 1'b1;
    end else if (clr_i) begin
      last_valid_o <= 1'b0;
    end
  end

  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !record_i) |=> !last_valid_o); // R12
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !record_i |=> $stable(last_mode_o)); // R12
endmodule

// File: rtl/lp_mode_ctrl.sv
module lp_mode_ctrl
  import lpm_pkg::*;
#(
  parameter int NCPU      = 2,
  parameter int ENTRY_CYC = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCPU-1:0] cpu_stop_i,
  input  logic            entry_req_i,
  input  logic [2:0]      mode_i,
  input  logic            retain_i,
  input  logic            secure_boot_i,
  input  logic            wake_hsi_i,
  input  logic            wake_i,
  input  logic            msi_rdy_i,
  input  logic            hsi_rdy_i,
  input  logic            stat_clr_i,
  output logic            main_reg_en_o,
  output logic            lp_reg_en_o,
  output logic            core_pwr_o,
  output logic            pll_en_o,
  output logic            msi_en_o,
  output logic            hsi_en_o,
  output logic            hse_en_o,
  output logic            sram2_ret_o,
  output logic            pvd_low_o,
  output logic            sup_mon_o,
  output logic [1:0]      clk_sel_o,
  output logic            cpu_hold_o,
  output logic            wake_done_o,
  output logic [2:0]      last_mode_o,
  output logic            last_valid_o
);
  lpm_state_e state;
  lpm_mode_e  mode_lat;
  wclk_e      wclk;
  logic       accept, ret_lat, record;
  pwr_vec_t   pv;

  lpm_gate #(.NCPU(NCPU)) u_gate (
    .cpu_stop_i (cpu_stop_i),
    .req_i      (entry_req_i),
    .mode_i     (mode_i),
    .secure_i   (secure_boot_i),
    .idle_i     (state == ST_RUN),
    .accept_o   (accept)
  );

  lpm_fsm #(.ENTRY_CYC(ENTRY_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .mode_i     (mode_i),
    .retain_i   (retain_i),
    .wake_hsi_i (wake_hsi_i),
    .wake_i     (wake_i),
    .msi_rdy_i  (msi_rdy_i),
    .hsi_rdy_i  (hsi_rdy_i),
    .state_o    (state),
    .mode_o     (mode_lat),
    .retain_o   (ret_lat),
    .wclk_o     (wclk),
    .done_o     (wake_done_o),
    .record_o   (record)
  );

  lpm_enables u_en (
    .state_i  (state),
    .mode_i   (mode_lat),
    .retain_i (ret_lat),
    .wclk_i   (wclk),
    .vec_o    (pv)
  );

  lpm_status u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .record_i     (record),
    .mode_i       (mode_lat),
    .clr_i        (stat_clr_i),
    .last_mode_o  (last_mode_o),
    .last_valid_o (last_valid_o)
  );

  assign main_reg_en_o = pv.main_reg;
  assign lp_reg_en_o   = pv.lp_reg;
  assign core_pwr_o    = pv.core_pwr;
  assign pll_en_o      = pv.pll;
  assign msi_en_o      = pv.msi;
  assign hsi_en_o      = pv.hsi;
  assign hse_en_o      = pv.hse;
  assign sram2_ret_o   = pv.sram2_ret;
  assign pvd_low_o     = pv.pvd_low;
  assign sup_mon_o     = pv.sup_mon;
  assign clk_sel_o     = wclk;
  assign cpu_hold_o    = (state != ST_RUN);

  AST_ALL_CPUS_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_hold_o) |-> $past(&cpu_stop_i)); // R1
  AST_NO_SECURE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_hold_o) |-> !$past(secure_boot_i)); // R2
  AST_LEGAL_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_hold_o) |-> $past(mode_i) <= 3'd4); // R3
  AST_ONE_REGULATOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_reg_en_o && lp_reg_en_o)); // R6
  AST_MON_OFF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sup_mon_o |-> cpu_hold_o && !core_pwr_o); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |-> !cpu_hold_o ##1 !wake_done_o); // R10
endmodule

// File: tb/lp_mode_ctrl_bench.sv
`timescale 1ns/1ps
module lp_mode_ctrl_bench;
  localparam int NCPU = 2;
  localparam int ENTRY_CYC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCPU-1:0] cpu_stop = '0;
  logic entry_req = 0, retain = 0, secure = 0, wake_hsi = 0, wake = 0;
  logic msi_rdy = 0, hsi_rdy = 0, stat_clr = 0;
  logic [2:0] mode = '0;
  logic main_reg, lp_reg, core_pwr, pll, msi, hsi, hse, sram2, pvd_low, sup_mon;
  logic [1:0] clk_sel;
  logic hold, done, last_valid;
  logic [2:0] last_mode;

  int nchk = 0, nfail = 0;
  logic [2:0] exp_last = '0;
  logic exp_valid = 1'b0;
  bit finished = 0;

  always #5 clk = ~clk;

  lp_mode_ctrl #(.NCPU(NCPU), .ENTRY_CYC(ENTRY_CYC)) u_lp_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cpu_stop_i(cpu_stop), .entry_req_i(entry_req),
    .mode_i(mode), .retain_i(retain), .secure_boot_i(secure), .wake_hsi_i(wake_hsi),
    .wake_i(wake), .msi_rdy_i(msi_rdy), .hsi_rdy_i(hsi_rdy), .stat_clr_i(stat_clr),
    .main_reg_en_o(main_reg), .lp_reg_en_o(lp_reg), .core_pwr_o(core_pwr),
    .pll_en_o(pll), .msi_en_o(msi), .hsi_en_o(hsi), .hse_en_o(hse),
    .sram2_ret_o(sram2), .pvd_low_o(pvd_low), .sup_mon_o(sup_mon),
    .clk_sel_o(clk_sel), .cpu_hold_o(hold), .wake_done_o(done),
    .last_mode_o(last_mode), .last_valid_o(last_valid));

  function automatic logic [9:0] pv_act();
    return {main_reg, lp_reg, core_pwr, pll, msi, hsi, hse, sram2, pvd_low, sup_mon};
  endfunction

  // {main, lp, core, pll, msi, hsi, hse, sram2, pvd_low, mon}
  function automatic logic [9:0] exp_deep(logic [2:0] m, logic r);
    case (m)
      3'd0:       return 10'b1_0_1_0000_1_0_1;
      3'd1, 3'd2: return 10'b0_1_1_0000_1_0_1;
      3'd3:       return {1'b0, r, 1'b0, 4'b0000, r, 1'b1, 1'b1};
      default:    return 10'b0;
    endcase
  endfunction

  function automatic logic [1:0] exp_wclk(logic [2:0] m, logic h);
    return (m <= 3'd2) ? (h ? 2'd2 : 2'd1) : 2'd0;
  endfunction

  function automatic string mode_tag(logic [2:0] m);
    case (m)
      3'd0: return "R5";
      3'd1, 3'd2: return "R6";
      3'd3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic trial(logic [2:0] m, logic [NCPU-1:0] cs, logic sec, logic r, logic h);
    logic acc;
    logic [1:0] wc;
    acc = (m <= 3'd4) && (&cs) && !sec;
    wc  = exp_wclk(m, h);
    mode = m; cpu_stop = cs; secure = sec; retain = r; wake_hsi = h; entry_req = 1;
    @(negedge clk);
    entry_req = 0;
    if (!acc) begin
      if (sec)            chk("R2 secure blocks entry", hold, 0);
      else if (!(&cs))    chk("R1 cpu awake blocks entry", hold, 0);
      else                chk("R3 illegal code ignored", hold, 0);
      chk("R3 status untouched", {last_valid, last_mode}, {exp_valid, exp_last});
      return;
    end
    chk("R4 hold after strobe", hold, 1);
    repeat (ENTRY_CYC - 1) @(negedge clk);
    chk("R4 run vector during entry", pv_act(), 10'b1_0_1_1111_1_0_1);
    @(negedge clk);
    chk(mode_tag(m), pv_act(), exp_deep(m, r));
    exp_last = m; exp_valid = 1;
    chk("R12 record", {last_valid, last_mode}, {exp_valid, exp_last});
    wake = 1;
    @(negedge clk);
    wake = 0;
    chk("R10 held in wake", {hold, done}, 2'b10);
    chk("R10 wake vector", {main_reg, core_pwr, pll, hse, msi, hsi},
        {4'b1100, wc != 2'd2, wc == 2'd2});
    if (wc == 2'd2) msi_rdy = 1; else hsi_rdy = 1;
    @(negedge clk);
    chk("R10 wrong ready ignored", hold, 1);
    msi_rdy = 1; hsi_rdy = 1;
    if (wc == 2'd2) msi_rdy = 0; else hsi_rdy = 0;
    @(negedge clk);
    msi_rdy = 0; hsi_rdy = 0;
    chk("R10 release pulse", {hold, done}, 2'b01);
    chk("R9 restart clock", clk_sel, wc);
    @(negedge clk);
    chk("R10 pulse one cycle", done, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 reset hold/done", {hold, done, last_valid, clk_sel}, 5'b0);
    chk("R5 reset run vector", pv_act(), 10'b1_0_1_1111_1_0_1);

    // directed corner cases
    trial(3'd0, 2'b11, 0, 0, 0);
    trial(3'd1, 2'b11, 0, 0, 1);
    trial(3'd2, 2'b11, 0, 1, 0);
    trial(3'd3, 2'b11, 0, 1, 1);
    trial(3'd3, 2'b11, 0, 0, 0);
    trial(3'd4, 2'b11, 0, 1, 1);
    trial(3'd1, 2'b01, 0, 0, 0);
    trial(3'd1, 2'b10, 0, 0, 0);
    trial(3'd0, 2'b11, 1, 0, 0);
    trial(3'd5, 2'b11, 0, 0, 0);
    trial(3'd7, 2'b11, 0, 0, 0);

    // R11 abort during entry
    mode = 3'd2; cpu_stop = 2'b11; secure = 0; entry_req = 1;
    @(negedge clk);
    entry_req = 0; wake = 1;
    @(negedge clk);
    wake = 0;
    chk("R11 abort to run", {hold, done}, 2'b00);
    repeat (ENTRY_CYC + 1) @(negedge clk);
    chk("R11 stays in run", {hold, done}, 2'b00);
    chk("R11 status unchanged", {last_valid, last_mode}, {exp_valid, exp_last});

    // R12 clear
    stat_clr = 1;
    @(negedge clk);
    stat_clr = 0;
    exp_valid = 0;
    chk("R12 clear", last_valid, 0);

    // random trials
    for (int i = 0; i < 60; i++) begin
      logic [NCPU-1:0] cs;
      cs = ($urandom % 4 == 0) ? NCPU'($urandom) : '1;
      trial(3'($urandom % 8), cs, ($urandom % 6 == 0), 1'($urandom), 1'($urandom));
      @(negedge clk);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule